// File: doc/BRIEF.md
# Compacted Warp Stack Frame Address Generator

This block turns a warp's active-lane mask into per-lane word addresses for a stack frame that is only as wide as the number of lanes actually running. The frame width is the number of set bits in the mask. A lane's compact rank is the number of active lanes with a lower lane number. Stack slot k of a lane then sits at `sp - k*width + rank`, so each slot of the frame is one dense row with no holes for idle lanes.

All lanes of a warp share one stack pointer. The block takes the current pointer on `sp_in`. On an allocate command it returns the pointer lowered by `n_slots*width`. On a release command it returns the pointer raised by the same amount. The caller must present the same active mask at release as at allocation, which is the mask at the same nesting level, so that the two steps cancel.

A four-state machine records the command class accepted on the last edge:

- ST_IDLE: no command.
- ST_GROW: allocate.
- ST_SHRINK: release.
- ST_CLASH: allocate and release together.

Every edge goes to the state named by the current pair of request bits, from any state. The outputs are decoded from the registered state. All outputs appear one clock after their inputs.

Top module: `csf_frame_addr`

## Requirements
- R1: While reset is asserted (`rst_n` low), `sp_out`, `lane_vld`, `frame_width`, `clash_err` and every lane address read zero.
- R2: One clock after the inputs, `frame_width` equals the number of set bits of `act_mask`, a value from 0 to 32.
- R3: One clock after the inputs, `lane_vld` bit i equals `act_mask` bit i.
- R4: For an active lane i, the 32-bit field `lane_addr[32*i+31:32*i]` one clock later equals `sp_in - slot_k*width + rank_i`. Here rank_i is the count of set mask bits below bit i, and the arithmetic is in 32-bit word units modulo 2^32.
- R5: The address field of an inactive lane reads zero.
- R6: With only `alloc_req` high, `sp_out` one clock later equals `sp_in - n_slots*width`, modulo 2^32.
- R7: With only `free_req` high, `sp_out` one clock later equals `sp_in + n_slots*width`, modulo 2^32.
- R8: With neither request high, `sp_out` one clock later equals `sp_in`.
- R9: With both requests high, the command is rejected. `sp_out` one clock later equals `sp_in`, and `clash_err` is high for exactly that one cycle.
- R10: An allocate followed, after nested frames have come and gone, by a release under the same mask and slot count returns the pointer to its value before the allocate.
- R11: For any non-empty mask, the active lanes' addresses for one slot are distinct and fill exactly the range `sp_in - slot_k*width` up to that base plus `width - 1`.
- R12: An all-zero mask gives width 0, and an allocate or release then leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_mask | input | 32 | Active-lane mask, bit i is lane i |
| slot_k | input | 4 | Slot number to address within the frame |
| alloc_req | input | 1 | Allocate a frame of `n_slots` rows |
| free_req | input | 1 | Release a frame of `n_slots` rows |
| n_slots | input | 4 | Rows in the frame being allocated or released |
| sp_in | input | 32 | Current warp stack pointer, word units |
| lane_addr | output | 1024 | Per-lane word addresses, lane i in bits 32*i+31:32*i |
| lane_vld | output | 32 | Per-lane address valid |
| frame_width | output | 6 | Active-lane count used as the row stride |
| sp_out | output | 32 | Updated stack pointer |
| clash_err | output | 1 | One-cycle pulse for a rejected allocate-plus-release |

## Verification
The full mask checks that the stride reduces to the warp size and that ranks equal lane numbers. Single-lane masks at both ends of the warp check that a lone lane gets rank 0 and stride 1, wherever it sits. Alternating and half-warp masks separate the compact rank from the raw lane number. The empty mask shows that the stride can collapse to zero without disturbing the pointer. Random masks with all four command classes, nested allocate and release pairs, a pointer that wraps below zero, and a clash followed by a quiet cycle separate the four state transitions and confirm that the error lasts one cycle.

// File: rtl/csf_pkg.sv
package csf_pkg;

    // Command class accepted on the previous clock edge
    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_GROW   = 2'b01,
        ST_SHRINK = 2'b10,
        ST_CLASH  = 2'b11
    } sp_state_e;

endpackage

// File: rtl/csf_lane_rank.sv
// Derives the active-lane count and every lane's rank among active lanes.
module csf_lane_rank #(
    parameter int LANES = 32,
    parameter int WID_W = 6
) (
    input  logic [LANES-1:0]       mask,
    output logic [WID_W-1:0]       width,
    output logic [LANES*WID_W-1:0] rank_flat
);

    logic [WID_W-1:0] rank_a [LANES];

    assign rank_a[0] = '0;

    // Ripple prefix count: rank of lane i counts set bits below i
    for (genvar i = 1; i < LANES; i++) begin : g_prefix
        assign rank_a[i] = rank_a[i-1] + WID_W'(mask[i-1]);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_flat
        assign rank_flat[i*WID_W +: WID_W] = rank_a[i];
    end

    assign width = rank_a[LANES-1] + WID_W'(mask[LANES-1]);

endmodule

// File: rtl/csf_slot_addr.sv
// Registers the per-lane slot addresses and the frame width.
module csf_slot_addr #(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32,
    parameter int SLOT_W = 4,
    parameter int WID_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        mask,
    input  logic [LANES*WID_W-1:0]  rank_flat,
    input  logic [WID_W-1:0]        width,
    input  logic [SLOT_W-1:0]       slot_k,
    input  logic [ADDR_W-1:0]       sp_in,
    output logic [LANES*ADDR_W-1:0] lane_addr,
    output logic [LANES-1:0]        lane_vld,
    output logic [WID_W-1:0]        frame_width
);

    logic [ADDR_W-1:0] row_base;

    // Lowest word of the requested slot row
    assign row_base = sp_in - (ADDR_W'(slot_k) * ADDR_W'(width));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_width <= '0;
        end else begin
            frame_width <= width;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [ADDR_W-1:0] addr_q;
        logic              vld_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q <= '0;
                vld_q  <= 1'b0;
            end else begin
                vld_q  <= mask[i];
                addr_q <= mask[i] ? row_base + ADDR_W'(rank_flat[i*WID_W +: WID_W])
                                  : '0;
            end
        end

        assign lane_addr[i*ADDR_W +: ADDR_W] = addr_q;
        assign lane_vld[i]                   = vld_q;
    end

endmodule

// File: rtl/csf_sp_fsm.sv
// Stack pointer update controller for the shared warp pointer.
module csf_sp_fsm
    import csf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 4,
    parameter int WID_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    input  logic              free_req,
    input  logic [CNT_W-1:0]  n_slots,
    input  logic [WID_W-1:0]  width,
    input  logic [ADDR_W-1:0] sp_in,
    output logic [ADDR_W-1:0] sp_out,
    output logic              clash_err
);

    sp_state_e         state_q, state_d;
    logic [ADDR_W-1:0] sp_q;
    logic [ADDR_W-1:0] step_q;

    // Next state follows the request pair, from any state
    always_comb begin
        unique case ({free_req, alloc_req})
            2'b00:   state_d = ST_IDLE;
            2'b01:   state_d = ST_GROW;
            2'b10:   state_d = ST_SHRINK;
            2'b11:   state_d = ST_CLASH;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with captured operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sp_q    <= '0;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            sp_q    <= sp_in;
            step_q  <= ADDR_W'(n_slots) * ADDR_W'(width);
        end
    end

    // Output decode from the registered state
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                sp_out    = sp_q;
                clash_err = 1'b0;
            end
            ST_GROW: begin
                sp_out    = sp_q - step_q;
                clash_err = 1'b0;
            end
            ST_SHRINK: begin
                sp_out    = sp_q + step_q;
                clash_err = 1'b0;
            end
            ST_CLASH: begin
                sp_out    = sp_q;
                clash_err = 1'b1;
            end
            default: begin
                sp_out    = sp_q;
                clash_err = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/csf_frame_addr.sv
// Top: compacted warp stack frame address generator.
module csf_frame_addr #(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32,
    parameter int SLOT_W = 4,
    parameter int CNT_W  = 4,
    localparam int WID_W = $clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        act_mask,
    input  logic [SLOT_W-1:0]       slot_k,
    input  logic                    alloc_req,
    input  logic                    free_req,
    input  logic [CNT_W-1:0]        n_slots,
    input  logic [ADDR_W-1:0]       sp_in,
    output logic [LANES*ADDR_W-1:0] lane_addr,
    output logic [LANES-1:0]        lane_vld,
    output logic [WID_W-1:0]        frame_width,
    output logic [ADDR_W-1:0]       sp_out,
    output logic                    clash_err
);

    logic [WID_W-1:0]       cur_width;
    logic [LANES*WID_W-1:0] cur_rank;

    csf_lane_rank #(
        .LANES (LANES),
        .WID_W (WID_W)
    ) u_rank (
        .mask      (act_mask),
        .width     (cur_width),
        .rank_flat (cur_rank)
    );

    csf_slot_addr #(
        .LANES  (LANES),
        .ADDR_W (ADDR_W),
        .SLOT_W (SLOT_W),
        .WID_W  (WID_W)
    ) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .mask        (act_mask),
        .rank_flat   (cur_rank),
        .width       (cur_width),
        .slot_k      (slot_k),
        .sp_in       (sp_in),
        .lane_addr   (lane_addr),
        .lane_vld    (lane_vld),
        .frame_width (frame_width)
    );

    csf_sp_fsm #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .WID_W  (WID_W)
    ) u_sp (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_req (alloc_req),
        .free_req  (free_req),
        .n_slots   (n_slots),
        .width     (cur_width),
        .sp_in     (sp_in),
        .sp_out    (sp_out),
        .clash_err (clash_err)
    );

endmodule

// File: rtl/csf_frame_addr_chk.sv
// Property checker attached to the top module.
module csf_frame_addr_chk #(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 4,
    parameter int WID_W  = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [LANES-1:0]        act_mask,
    input logic                    alloc_req,
    input logic                    free_req,
    input logic [CNT_W-1:0]        n_slots,
    input logic [ADDR_W-1:0]       sp_in,
    input logic [LANES*ADDR_W-1:0] lane_addr,
    input logic [LANES-1:0]        lane_vld,
    input logic [WID_W-1:0]        frame_width,
    input logic [ADDR_W-1:0]       sp_out,
    input logic                    clash_err
);

    logic [LANES-1:0] addr_nz;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            addr_nz[i] = |lane_addr[i*ADDR_W +: ADDR_W];
        end
    end

    assert_reset_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (sp_out == '0 && lane_vld == '0 && !clash_err && frame_width == '0));

    assert_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (32'(frame_width) == 32'($countones($past(act_mask)))));

    assert_vld_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lane_vld == $past(act_mask)));

    assert_idle_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr_nz & ~lane_vld) == '0));

    assert_grow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && !free_req) |=>
        (sp_out == $past(sp_in) - ADDR_W'($past(n_slots)) * ADDR_W'($countones($past(act_mask)))));

    assert_shrink_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_req && free_req) |=>
        (sp_out == $past(sp_in) + ADDR_W'($past(n_slots)) * ADDR_W'($countones($past(act_mask)))));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_req && !free_req) |=> (sp_out == $past(sp_in) && !clash_err));

    assert_clash_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && free_req) |=> (clash_err && sp_out == $past(sp_in)));

    assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(alloc_req && free_req) |=> !clash_err);

endmodule

bind csf_frame_addr csf_frame_addr_chk #(
    .LANES  (LANES),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .WID_W  (WID_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .act_mask    (act_mask),
    .alloc_req   (alloc_req),
    .free_req    (free_req),
    .n_slots     (n_slots),
    .sp_in       (sp_in),
    .lane_addr   (lane_addr),
    .lane_vld    (lane_vld),
    .frame_width (frame_width),
    .sp_out      (sp_out),
    .clash_err   (clash_err)
);

// File: tb/sim_csf_frame_addr.sv
`timescale 1ns/100ps
module sim_csf_frame_addr;

    localparam int LANES = 32;
    localparam int AW    = 32;
    localparam int SW    = 4;
    localparam int CW    = 4;
    localparam int WW    = 6;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n;
    logic [LANES-1:0]  act_mask;
    logic [SW-1:0]     slot_k;
    logic              alloc_req;
    logic              free_req;
    logic [CW-1:0]     n_slots;
    logic [AW-1:0]     sp_in;
    logic [LANES*AW-1:0] lane_addr;
    logic [LANES-1:0]  lane_vld;
    logic [WW-1:0]     frame_width;
    logic [AW-1:0]     sp_out;
    logic              clash_err;

    csf_frame_addr u0 (
        .clk (clk), .rst_n (rst_n), .act_mask (act_mask), .slot_k (slot_k),
        .alloc_req (alloc_req), .free_req (free_req), .n_slots (n_slots),
        .sp_in (sp_in), .lane_addr (lane_addr), .lane_vld (lane_vld),
        .frame_width (frame_width), .sp_out (sp_out), .clash_err (clash_err)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference expectations for the next sampling point
    logic [AW-1:0]    e_addr [LANES];
    logic [LANES-1:0] e_vld;
    int               e_width;
    logic [AW-1:0]    e_sp;
    logic             e_err;
    string            e_tag;
    int               e_base;

    task automatic chk(input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        for (int i = 0; i < LANES; i++) begin
            chk(e_vld[i] ? "R4" : "R5", $sformatf("addr lane %0d", i),
                lane_addr[i*AW +: AW], e_addr[i]);
        end
        chk("R3", "valid mask", lane_vld, e_vld);
        chk("R2", "frame width", AW'(frame_width), AW'(e_width));
        chk(e_tag, "stack pointer", sp_out, e_sp);
        chk("R9", "clash flag", AW'(clash_err), AW'(e_err));
    endtask

    // Drive one cycle of inputs, model it, sample at the next falling edge
    task automatic cyc(input logic [LANES-1:0] m, input int k, input bit al,
                       input bit fr, input int n, input logic [AW-1:0] sp);
        int w;
        int r;
        logic [AW-1:0] step;
        act_mask  = m;
        slot_k    = SW'(k);
        alloc_req = al;
        free_req  = fr;
        n_slots   = CW'(n);
        sp_in     = sp;
        w = 0;
        for (int i = 0; i < LANES; i++) if (m[i]) w++;
        r = 0;
        for (int i = 0; i < LANES; i++) begin
            if (m[i]) begin
                e_addr[i] = sp - AW'(k * w) + AW'(r);
                r++;
            end else begin
                e_addr[i] = '0;
            end
        end
        e_vld   = m;
        e_width = w;
        e_base  = k * w;
        step    = AW'(n * w);
        e_err   = al && fr;
        if (al && fr)      begin e_sp = sp;        e_tag = "R9"; end
        else if (al)       begin e_sp = sp - step; e_tag = "R6"; end
        else if (fr)       begin e_sp = sp + step; e_tag = "R7"; end
        else               begin e_sp = sp;        e_tag = "R8"; end
        if (m == '0 && !(al && fr)) e_tag = "R12";
        @(negedge clk);
        compare_all();
    endtask

    // R11: active addresses of the sampled slot are distinct and dense
    task automatic contig(input logic [AW-1:0] sp);
        bit seen [LANES];
        logic [AW-1:0] base;
        logic [AW-1:0] off;
        bit ok;
        ok   = 1'b1;
        base = sp - AW'(e_base);
        for (int i = 0; i < LANES; i++) seen[i] = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (lane_vld[i]) begin
                off = lane_addr[i*AW +: AW] - base;
                if (off >= AW'(e_width) || seen[off[4:0]]) ok = 1'b0;
                else seen[off[4:0]] = 1'b1;
            end
        end
        chk("R11", "dense distinct row", AW'(ok), 32'd1);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] outer_sp;
        logic [AW-1:0] s1;
        logic [AW-1:0] s2;
        rst_n = 1'b0; act_mask = '1; slot_k = '0; alloc_req = 1'b1;
        free_req = 1'b0; n_slots = 4'd3; sp_in = 32'h55;
        repeat (3) @(negedge clk);
        // R1: reset values while reset is held
        chk("R1", "reset sp", sp_out, '0);
        chk("R1", "reset valid", lane_vld, '0);
        chk("R1", "reset width", AW'(frame_width), '0);
        chk("R1", "reset clash", AW'(clash_err), '0);
        chk("R1", "reset addr lane 5", lane_addr[5*AW +: AW], '0);
        rst_n = 1'b1;

        // Full warp, single lanes at both ends, alternating and half masks
        cyc(32'hFFFF_FFFF, 1, 1'b1, 1'b0, 3, 32'd1000);     contig(32'd1000);
        cyc(32'h8000_0000, 1, 1'b0, 1'b0, 0, 32'd500);
        cyc(32'h0000_0001, 2, 1'b1, 1'b0, 4, 32'd500);
        cyc(32'hAAAA_AAAA, 3, 1'b0, 1'b1, 2, 32'h2000);     contig(32'h2000);
        cyc(32'h0000_FFFF, 2, 1'b0, 1'b0, 1, 32'h300);      contig(32'h300);

        // R10: nested frames, outer released under the same mask
        outer_sp = 32'h4000;
        cyc(32'hAAAA_AAAA, 2, 1'b1, 1'b0, 2, outer_sp);
        s1 = sp_out;
        cyc(32'h0000_00F0, 1, 1'b1, 1'b0, 5, s1);
        s2 = sp_out;
        cyc(32'h0000_00F0, 1, 1'b0, 1'b1, 5, s2);
        chk("R10", "inner round trip", sp_out, s1);
        cyc(32'hAAAA_AAAA, 2, 1'b0, 1'b1, 2, sp_out);
        chk("R10", "outer round trip", sp_out, outer_sp);

        // R9: clash then a quiet cycle clears the pulse
        cyc(32'h0F0F_0F0F, 1, 1'b1, 1'b1, 5, 32'h800);
        cyc(32'h0F0F_0F0F, 1, 1'b0, 1'b0, 5, 32'h800);
        cyc(32'hFFFF_FFFF, 1, 1'b1, 1'b1, 15, 32'h900);
        cyc(32'hFFFF_FFFF, 1, 1'b1, 1'b1, 15, 32'h900);
        cyc(32'hFFFF_FFFF, 1, 1'b1, 1'b0, 1, 32'h900);

        // R12: empty warp leaves the pointer where it is
        cyc('0, 3, 1'b1, 1'b0, 7, 32'h100);
        cyc('0, 3, 1'b0, 1'b1, 7, 32'h100);

        // Pointer wrap below zero
        cyc(32'hFFFF_FFFF, 15, 1'b1, 1'b0, 15, 32'h10);

        // Random traffic over all command classes
        for (int t = 0; t < 400; t++) begin
            logic [LANES-1:0] m;
            logic [AW-1:0]    sp;
            m  = $urandom;
            if (t % 7 == 0) m = m & $urandom;
            sp = $urandom;
            cyc(m, $urandom_range(0, 15), 1'($urandom), 1'($urandom),
                $urandom_range(0, 15), sp);
            if (m != '0) contig(sp);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule